// File: doc/BRIEF.md
# Operand-Capturing Issue Pool

The block is the waiting room between register renaming and the execution ports of an out-of-order core. Renamed micro-ops come in on up to four allocation lanes per cycle. Each micro-op carries an opcode, a target execution port, one destination tag and two source operands. The pool keeps each micro-op until both of its operands hold values. It then hands the micro-op to its execution port as soon as that port can take it.

Rename supplies each source in one of two forms. The first is a value read from the committed register file, or from a reorder entry whose result is already complete; such a source is ready at once. The second is a physical tag that is still to be produced. Every result broadcast is compared against every waiting source in the pool. A match copies the data in and marks the source ready. A broadcast in the same cycle as the allocation is also seen.

Each cycle every port picks its oldest ready micro-op. An accepted micro-op leaves the pool in that cycle. A flush empties the whole pool at once.

Top module: `rsv_station`

## Requirements
- R1: Out of reset the pool is empty: every `disp_valid` bit is 0 and `alloc_ok` is 1.
- R2: `alloc_ok` is 1 exactly when at least 4 of the 20 entries are free. The caller presents allocations only while it is 1.
- R3: A source of kind 2'b00 (committed file) or 2'b01 (completed reorder entry) is ready with the value given at allocation. A micro-op whose two sources are both of these kinds can dispatch in the next cycle.
- R4: A source of kind 2'b10 or 2'b11 stores its tag and is not ready. Its micro-op is not offered for dispatch until that source is woken.
- R5: A valid broadcast on any of the 4 buses whose tag equals a waiting source's tag copies that bus's data into the source and makes it ready. The micro-op can dispatch from the next cycle. If two buses carry the same tag, the lower-numbered bus wins.
- R6: A waiting source whose tag is broadcast in its own allocation cycle captures that broadcast, and no wakeup is lost.
- R7: A micro-op is offered on a port only while both of its sources are ready. It stays in the pool and stays eligible while `disp_free` for its port is 0.
- R8: Among ready micro-ops for one port, the earliest allocated is offered. In a single cycle, a lower lane number counts as earlier.
- R9: The 2-bit port field selects one of 4 ports. Each port offers at most one micro-op per cycle, so up to 4 leave in the same cycle.
- R10: While `flush` is 1, no port is offered anything and allocations are dropped. In the next cycle the pool is empty.
- R11: An offered micro-op presents its opcode, destination tag and both source values on the port's outputs.
- R12: An entry frees in the cycle it is accepted, and `alloc_ok` reflects the freed space in the next cycle.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| flush | input | 1 | Discard every held micro-op |
| alloc_valid | input | 4 | Per-lane allocation request |
| alloc_op | input | 4x6 | Per-lane opcode |
| alloc_port | input | 4x2 | Per-lane target execution port |
| alloc_dst | input | 4x6 | Per-lane destination tag |
| alloc_a_kind | input | 4x2 | Source A kind: 00 committed, 01 completed entry, 1x wait |
| alloc_a_tag | input | 4x6 | Source A producer tag |
| alloc_a_val | input | 4x16 | Source A value when not waiting |
| alloc_b_kind | input | 4x2 | Source B kind, same coding |
| alloc_b_tag | input | 4x6 | Source B producer tag |
| alloc_b_val | input | 4x16 | Source B value when not waiting |
| alloc_ok | output | 1 | Room for a full group of four allocations |
| bc_valid | input | 4 | Per-bus result broadcast valid |
| bc_tag | input | 4x6 | Per-bus result tag |
| bc_data | input | 4x16 | Per-bus result data |
| disp_free | input | 4 | Per-port: port accepts a micro-op this cycle |
| disp_valid | output | 4 | Per-port: a micro-op is offered |
| disp_op | output | 4x6 | Offered opcode |
| disp_dst | output | 4x6 | Offered destination tag |
| disp_a | output | 4x16 | Offered source A value |
| disp_b | output | 4x16 | Offered source B value |

## Verification
The bench builds the pool at its default size: 20 entries, 4 lanes, 4 ports, 4 buses, 6-bit tags and 16-bit data. With 20 entries and groups of four, five cycles fill the pool exactly, so the point where `alloc_ok` falls and returns can be reached in a few cycles. A 6-bit tag space lets the random phase narrow tags to a small set. That makes same-cycle captures, duplicate tags on several buses, and wakeups of many entries at once happen often. Four ports with four lanes let all ports dispatch in the same cycle, and let several same-cycle allocations compete for one port.

// File: rtl/rsv_pkg.sv
package rsv_pkg;

    localparam int RS_ENTRIES = 20;
    localparam int RS_LANES   = 4;
    localparam int RS_PORTS   = 4;
    localparam int RS_BUSES   = 4;
    localparam int RS_TAG_W   = 6;
    localparam int RS_DATA_W  = 16;
    localparam int RS_OP_W    = 6;

    // How rename delivers one source operand.
    typedef enum logic [1:0] {
        SRC_COMMITTED = 2'b00,
        SRC_DONE_ROB  = 2'b01,
        SRC_WAIT      = 2'b10,
        SRC_WAIT_ALT  = 2'b11
    } src_kind_e;

    function automatic logic kind_waits(input logic [1:0] kind);
        return kind[1];
    endfunction

    function automatic int idx_width(input int n);
        return (n > 1) ? $clog2(n) : 1;
    endfunction

endpackage

// File: rtl/rsv_operand.sv
module rsv_operand
    import rsv_pkg::*;
#(
    parameter int TAG_W  = RS_TAG_W,
    parameter int DATA_W = RS_DATA_W,
    parameter int BUSES  = RS_BUSES
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          load,
    input  logic [1:0]                    load_kind,
    input  logic [TAG_W-1:0]              load_tag,
    input  logic [DATA_W-1:0]             load_val,
    input  logic [BUSES-1:0]              bc_valid,
    input  logic [BUSES-1:0][TAG_W-1:0]   bc_tag,
    input  logic [BUSES-1:0][DATA_W-1:0]  bc_data,
    output logic                          ready,
    output logic [TAG_W-1:0]              tag,
    output logic [DATA_W-1:0]             value
);

    logic [TAG_W-1:0]  look_tag;
    logic              hit;
    logic [DATA_W-1:0] hit_data;

    // While loading, compare against the incoming tag so a broadcast in the
    // allocation cycle is not missed.
    assign look_tag = load ? load_tag : tag;

    always_comb begin
        hit      = 1'b0;
        hit_data = '0;
        for (int b = BUSES - 1; b >= 0; b--) begin
            if (bc_valid[b] && (bc_tag[b] == look_tag)) begin
                hit      = 1'b1;
                hit_data = bc_data[b];
            end
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ready <= 1'b0;
            tag   <= '0;
            value <= '0;
        end else if (load) begin
            tag <= load_tag;
            if (!kind_waits(load_kind)) begin
                ready <= 1'b1;
                value <= load_val;
            end else if (hit) begin
                ready <= 1'b1;
                value <= hit_data;
            end else begin
                ready <= 1'b0;
            end
        end else if (!ready && hit) begin
            ready <= 1'b1;
            value <= hit_data;
        end
    end

endmodule

// File: rtl/rsv_age.sv
module rsv_age
    import rsv_pkg::*;
#(
    parameter int N      = RS_ENTRIES,
    parameter int LANE_W = 2
) (
    input  logic                         clk,
    input  logic                         rst,
    input  logic [N-1:0]                 new_hit,
    input  logic [N-1:0][LANE_W-1:0]     new_lane,
    output logic [N-1:0][N-1:0]          older
);

    // older[i][j] = 1 means entry i was allocated before entry j.
    always_ff @(posedge clk) begin
        if (rst) begin
            older <= '0;
        end else begin
            for (int i = 0; i < N; i++) begin
                for (int j = 0; j < N; j++) begin
                    if (new_hit[i] && new_hit[j]) begin
                        older[i][j] <= (new_lane[i] < new_lane[j]);
                    end else if (new_hit[i]) begin
                        older[i][j] <= 1'b0;
                    end else if (new_hit[j]) begin
                        older[i][j] <= 1'b1;
                    end
                end
            end
        end
    end

endmodule

// File: rtl/rsv_pick.sv
module rsv_pick
    import rsv_pkg::*;
#(
    parameter int N = RS_ENTRIES
) (
    input  logic [N-1:0]          cand,
    input  logic [N-1:0][N-1:0]   older,
    output logic [N-1:0]          grant
);

    logic [N-1:0] beaten;

    always_comb begin
        for (int i = 0; i < N; i++) begin
            beaten[i] = 1'b0;
            for (int j = 0; j < N; j++) begin
                if ((j != i) && cand[j] && older[j][i]) begin
                    beaten[i] = 1'b1;
                end
            end
            grant[i] = cand[i] && !beaten[i];
        end
    end

endmodule

// File: rtl/rsv_station.sv
module rsv_station
    import rsv_pkg::*;
#(
    parameter int ENTRIES = RS_ENTRIES,
    parameter int LANES   = RS_LANES,
    parameter int PORTS   = RS_PORTS,
    parameter int BUSES   = RS_BUSES,
    parameter int TAG_W   = RS_TAG_W,
    parameter int DATA_W  = RS_DATA_W,
    parameter int OP_W    = RS_OP_W,
    localparam int PSEL_W = idx_width(PORTS)
) (
    input  logic                           clk,
    input  logic                           rst,
    input  logic                           flush,
    input  logic [LANES-1:0]               alloc_valid,
    input  logic [LANES-1:0][OP_W-1:0]     alloc_op,
    input  logic [LANES-1:0][PSEL_W-1:0]   alloc_port,
    input  logic [LANES-1:0][TAG_W-1:0]    alloc_dst,
    input  logic [LANES-1:0][1:0]          alloc_a_kind,
    input  logic [LANES-1:0][TAG_W-1:0]    alloc_a_tag,
    input  logic [LANES-1:0][DATA_W-1:0]   alloc_a_val,
    input  logic [LANES-1:0][1:0]          alloc_b_kind,
    input  logic [LANES-1:0][TAG_W-1:0]    alloc_b_tag,
    input  logic [LANES-1:0][DATA_W-1:0]   alloc_b_val,
    output logic                           alloc_ok,
    input  logic [BUSES-1:0]               bc_valid,
    input  logic [BUSES-1:0][TAG_W-1:0]    bc_tag,
    input  logic [BUSES-1:0][DATA_W-1:0]   bc_data,
    input  logic [PORTS-1:0]               disp_free,
    output logic [PORTS-1:0]               disp_valid,
    output logic [PORTS-1:0][OP_W-1:0]     disp_op,
    output logic [PORTS-1:0][TAG_W-1:0]    disp_dst,
    output logic [PORTS-1:0][DATA_W-1:0]   disp_a,
    output logic [PORTS-1:0][DATA_W-1:0]   disp_b
);

    localparam int LANE_W = idx_width(LANES);

    typedef struct packed {
        logic [OP_W-1:0]   op;
        logic [PSEL_W-1:0] port;
        logic [TAG_W-1:0]  dst;
    } uop_meta_t;

    logic [ENTRIES-1:0]                 live;
    uop_meta_t                          meta_q [ENTRIES];
    logic [ENTRIES-1:0]                 take;
    logic [ENTRIES-1:0][LANE_W-1:0]     take_lane;
    logic [ENTRIES-1:0]                 accept;
    logic [ENTRIES-1:0]                 a_rdy, b_rdy;
    logic [ENTRIES-1:0][TAG_W-1:0]      a_tag, b_tag;
    logic [ENTRIES-1:0][DATA_W-1:0]     a_val, b_val;
    logic [ENTRIES-1:0][ENTRIES-1:0]    older;
    logic [PORTS-1:0][ENTRIES-1:0]      cand;
    logic [PORTS-1:0][ENTRIES-1:0]      grant;

    // ---------------- free-entry assignment: lane k takes the k-th free slot
    always_comb begin : find_free
        int k;
        k         = 0;
        take      = '0;
        take_lane = '0;
        for (int i = 0; i < ENTRIES; i++) begin
            if (!live[i] && (k < LANES)) begin
                take[i]      = alloc_valid[k] && !flush;
                take_lane[i] = LANE_W'(k);
                k            = k + 1;
            end
        end
    end

    assign alloc_ok = ($countones(~live) >= LANES);

    // ---------------- per-entry storage
    for (genvar i = 0; i < ENTRIES; i++) begin : g_entry
        always_ff @(posedge clk) begin
            if (rst) begin
                meta_q[i] <= '0;
            end else if (take[i]) begin
                meta_q[i].op   <= alloc_op[take_lane[i]];
                meta_q[i].port <= alloc_port[take_lane[i]];
                meta_q[i].dst  <= alloc_dst[take_lane[i]];
            end
        end

        rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BUSES(BUSES)) u_src_a (
            .clk       (clk),
            .rst       (rst),
            .load      (take[i]),
            .load_kind (alloc_a_kind[take_lane[i]]),
            .load_tag  (alloc_a_tag[take_lane[i]]),
            .load_val  (alloc_a_val[take_lane[i]]),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .ready     (a_rdy[i]),
            .tag       (a_tag[i]),
            .value     (a_val[i])
        );

        rsv_operand #(.TAG_W(TAG_W), .DATA_W(DATA_W), .BUSES(BUSES)) u_src_b (
            .clk       (clk),
            .rst       (rst),
            .load      (take[i]),
            .load_kind (alloc_b_kind[take_lane[i]]),
            .load_tag  (alloc_b_tag[take_lane[i]]),
            .load_val  (alloc_b_val[take_lane[i]]),
            .bc_valid  (bc_valid),
            .bc_tag    (bc_tag),
            .bc_data   (bc_data),
            .ready     (b_rdy[i]),
            .tag       (b_tag[i]),
            .value     (b_val[i])
        );
    end

    always_ff @(posedge clk) begin
        if (rst || flush) begin
            live <= '0;
        end else begin
            live <= (live & ~accept) | take;
        end
    end

    // ---------------- allocation order
    rsv_age #(.N(ENTRIES), .LANE_W(LANE_W)) u_age (
        .clk      (clk),
        .rst      (rst),
        .new_hit  (take),
        .new_lane (take_lane),
        .older    (older)
    );

    // ---------------- per-port oldest-ready selection
    for (genvar p = 0; p < PORTS; p++) begin : g_port
        for (genvar i = 0; i < ENTRIES; i++) begin : g_cand
            assign cand[p][i] = live[i] && a_rdy[i] && b_rdy[i] &&
                                (meta_q[i].port == PSEL_W'(p));
        end

        rsv_pick #(.N(ENTRIES)) u_pick (
            .cand  (cand[p]),
            .older (older),
            .grant (grant[p])
        );

        assign disp_valid[p] = (|grant[p]) && !flush;

        always_comb begin
            disp_op[p]  = '0;
            disp_dst[p] = '0;
            disp_a[p]   = '0;
            disp_b[p]   = '0;
            for (int i = 0; i < ENTRIES; i++) begin
                if (grant[p][i]) begin
                    disp_op[p]  = disp_op[p]  | meta_q[i].op;
                    disp_dst[p] = disp_dst[p] | meta_q[i].dst;
                    disp_a[p]   = disp_a[p]   | a_val[i];
                    disp_b[p]   = disp_b[p]   | b_val[i];
                end
            end
        end
    end

    always_comb begin
        accept = '0;
        for (int p = 0; p < PORTS; p++) begin
            if (disp_free[p] && !flush) begin
                accept = accept | grant[p];
            end
        end
    end

endmodule

// File: rtl/rsv_station_chk.sv
module rsv_station_chk #(
    parameter int ENTRIES = 20,
    parameter int PORTS   = 4,
    parameter int BUSES   = 4,
    parameter int TAG_W   = 6
) (
    input  logic                          clk,
    input  logic                          rst,
    input  logic                          flush,
    input  logic                          alloc_ok,
    input  logic [PORTS-1:0]              disp_valid,
    input  logic [PORTS-1:0]              disp_free,
    input  logic [ENTRIES-1:0]            live,
    input  logic [PORTS-1:0][ENTRIES-1:0] grant,
    input  logic [ENTRIES-1:0]            a_rdy,
    input  logic [ENTRIES-1:0]            b_rdy,
    input  logic [ENTRIES-1:0][TAG_W-1:0] a_tag,
    input  logic [ENTRIES-1:0][TAG_W-1:0] b_tag,
    input  logic [BUSES-1:0]              bc_valid,
    input  logic [BUSES-1:0][TAG_W-1:0]   bc_tag
);

    logic [ENTRIES-1:0] a_hit, b_hit;

    always_comb begin
        for (int i = 0; i < ENTRIES; i++) begin
            a_hit[i] = 1'b0;
            b_hit[i] = 1'b0;
            for (int b = 0; b < BUSES; b++) begin
                if (bc_valid[b] && (bc_tag[b] == a_tag[i])) a_hit[i] = 1'b1;
                if (bc_valid[b] && (bc_tag[b] == b_tag[i])) b_hit[i] = 1'b1;
            end
        end
    end

    a_r1_reset_idle: assert property (@(posedge clk)
        rst |=> (disp_valid == '0) && alloc_ok);

    a_r10_flush_empties: assert property (@(posedge clk) disable iff (rst)
        flush |=> (disp_valid == '0) && alloc_ok);

    for (genvar p = 0; p < PORTS; p++) begin : g_p
        a_r9_one_per_port: assert property (@(posedge clk) disable iff (rst)
            $onehot0(grant[p]));

        for (genvar i = 0; i < ENTRIES; i++) begin : g_e
            a_r12_freed_on_accept: assert property (@(posedge clk) disable iff (rst)
                (grant[p][i] && disp_free[p] && !flush) |=> !live[i]);
        end
    end

    for (genvar i = 0; i < ENTRIES; i++) begin : g_w
        a_r5_wake_a: assert property (@(posedge clk) disable iff (rst)
            (live[i] && !a_rdy[i] && a_hit[i]) |=> a_rdy[i]);
        a_r5_wake_b: assert property (@(posedge clk) disable iff (rst)
            (live[i] && !b_rdy[i] && b_hit[i]) |=> b_rdy[i]);
    end

endmodule

bind rsv_station rsv_station_chk #(
    .ENTRIES (ENTRIES),
    .PORTS   (PORTS),
    .BUSES   (BUSES),
    .TAG_W   (TAG_W)
) u_chk (
    .clk        (clk),
    .rst        (rst),
    .flush      (flush),
    .alloc_ok   (alloc_ok),
    .disp_valid (disp_valid),
    .disp_free  (disp_free),
    .live       (live),
    .grant      (grant),
    .a_rdy      (a_rdy),
    .b_rdy      (b_rdy),
    .a_tag      (a_tag),
    .b_tag      (b_tag),
    .bc_valid   (bc_valid),
    .bc_tag     (bc_tag)
);

// File: tb/rsv_station_bench.sv
module rsv_station_bench;
    import rsv_pkg::*;

    localparam int CLK_PERIOD = 10;
    localparam int ENT = RS_ENTRIES;
    localparam int LN  = RS_LANES;
    localparam int NP  = RS_PORTS;
    localparam int NB  = RS_BUSES;
    localparam int TW  = RS_TAG_W;
    localparam int DW  = RS_DATA_W;
    localparam int OW  = RS_OP_W;
    localparam int PW  = (NP > 1) ? $clog2(NP) : 1;

    logic clk = 1'b0;
    logic rst = 1'b1;
    logic flush;
    logic [LN-1:0]          alloc_valid;
    logic [LN-1:0][OW-1:0]  alloc_op;
    logic [LN-1:0][PW-1:0]  alloc_port;
    logic [LN-1:0][TW-1:0]  alloc_dst;
    logic [LN-1:0][1:0]     alloc_a_kind, alloc_b_kind;
    logic [LN-1:0][TW-1:0]  alloc_a_tag, alloc_b_tag;
    logic [LN-1:0][DW-1:0]  alloc_a_val, alloc_b_val;
    logic                   alloc_ok;
    logic [NB-1:0]          bc_valid;
    logic [NB-1:0][TW-1:0]  bc_tag;
    logic [NB-1:0][DW-1:0]  bc_data;
    logic [NP-1:0]          disp_free;
    logic [NP-1:0]          disp_valid;
    logic [NP-1:0][OW-1:0]  disp_op;
    logic [NP-1:0][TW-1:0]  disp_dst;
    logic [NP-1:0][DW-1:0]  disp_a, disp_b;

    always #(CLK_PERIOD / 2) clk = ~clk;

    rsv_station u_rsv_station (
        .clk(clk), .rst(rst), .flush(flush),
        .alloc_valid(alloc_valid), .alloc_op(alloc_op), .alloc_port(alloc_port),
        .alloc_dst(alloc_dst), .alloc_a_kind(alloc_a_kind), .alloc_a_tag(alloc_a_tag),
        .alloc_a_val(alloc_a_val), .alloc_b_kind(alloc_b_kind), .alloc_b_tag(alloc_b_tag),
        .alloc_b_val(alloc_b_val), .alloc_ok(alloc_ok),
        .bc_valid(bc_valid), .bc_tag(bc_tag), .bc_data(bc_data),
        .disp_free(disp_free), .disp_valid(disp_valid), .disp_op(disp_op),
        .disp_dst(disp_dst), .disp_a(disp_a), .disp_b(disp_b)
    );

    // ---------------- behavioural reference
    bit            m_live [ENT];
    logic [OW-1:0] m_op   [ENT];
    int            m_port [ENT];
    logic [TW-1:0] m_dst  [ENT];
    bit            m_ra   [ENT];
    bit            m_rb   [ENT];
    logic [TW-1:0] m_ta   [ENT];
    logic [TW-1:0] m_tb   [ENT];
    logic [DW-1:0] m_va   [ENT];
    logic [DW-1:0] m_vb   [ENT];
    int            m_seq  [ENT];
    int            seq_ctr = 0;
    int            checks = 0;
    int            bad = 0;
    bit            done = 0;
    string         cur_req = "R1";

    function automatic int pick(input int p);
        int best = -1;
        for (int e = 0; e < ENT; e++) begin
            if (m_live[e] && m_ra[e] && m_rb[e] && (m_port[e] == p) &&
                ((best < 0) || (m_seq[e] < m_seq[best]))) best = e;
        end
        return best;
    endfunction

    function automatic int free_cnt();
        int n = 0;
        for (int e = 0; e < ENT; e++) if (!m_live[e]) n++;
        return n;
    endfunction

    function automatic bit bc_hit(input logic [TW-1:0] t, output logic [DW-1:0] d);
        d = '0;
        for (int b = 0; b < NB; b++) begin
            if (bc_valid[b] && (bc_tag[b] == t)) begin
                d = bc_data[b];
                return 1'b1;
            end
        end
        return 1'b0;
    endfunction

    task automatic chk(input string what, input logic [31:0] got, input logic [31:0] exp);
        checks++;
        if (got !== exp) begin
            bad++;
            $display("FAIL %s %s: got %0h exp %0h", cur_req, what, got, exp);
        end
    endtask

    task automatic compare();
        chk("R2 alloc_ok", 32'(alloc_ok), 32'(free_cnt() >= LN));
        for (int p = 0; p < NP; p++) begin
            int e = pick(p);
            bit ev = (e >= 0) && !flush;
            chk($sformatf("R7 valid port%0d", p), 32'(disp_valid[p]), 32'(ev));
            if (ev) begin
                chk($sformatf("R11 op port%0d", p),  32'(disp_op[p]),  32'(m_op[e]));
                chk($sformatf("R11 dst port%0d", p), 32'(disp_dst[p]), 32'(m_dst[e]));
                chk($sformatf("R11 a port%0d", p),   32'(disp_a[p]),   32'(m_va[e]));
                chk($sformatf("R11 b port%0d", p),   32'(disp_b[p]),   32'(m_vb[e]));
            end
        end
    endtask

    task automatic model_step();
        logic [DW-1:0] d;
        int win [NP];
        if (flush) begin
            for (int e = 0; e < ENT; e++) m_live[e] = 0;
            return;
        end
        for (int p = 0; p < NP; p++) win[p] = pick(p);
        for (int p = 0; p < NP; p++) if ((win[p] >= 0) && disp_free[p]) m_live[win[p]] = 0;
        for (int e = 0; e < ENT; e++) begin
            if (m_live[e]) begin
                if (!m_ra[e] && bc_hit(m_ta[e], d)) begin m_ra[e] = 1; m_va[e] = d; end
                if (!m_rb[e] && bc_hit(m_tb[e], d)) begin m_rb[e] = 1; m_vb[e] = d; end
            end
        end
        for (int l = 0; l < LN; l++) begin
            if (alloc_valid[l]) begin
                int e = 0;
                while ((e < ENT) && m_live[e]) e++;
                if (e < ENT) begin
                    m_live[e] = 1; m_op[e] = alloc_op[l]; m_port[e] = int'(alloc_port[l]);
                    m_dst[e] = alloc_dst[l]; m_seq[e] = seq_ctr; seq_ctr++;
                    m_ta[e] = alloc_a_tag[l]; m_tb[e] = alloc_b_tag[l];
                    if (!alloc_a_kind[l][1]) begin m_ra[e] = 1; m_va[e] = alloc_a_val[l]; end
                    else begin m_ra[e] = bc_hit(alloc_a_tag[l], d); m_va[e] = d; end
                    if (!alloc_b_kind[l][1]) begin m_rb[e] = 1; m_vb[e] = alloc_b_val[l]; end
                    else begin m_rb[e] = bc_hit(alloc_b_tag[l], d); m_vb[e] = d; end
                end
            end
        end
    endtask

    task automatic clear_inputs();
        flush = 0; alloc_valid = '0; alloc_op = '0; alloc_port = '0; alloc_dst = '0;
        alloc_a_kind = '0; alloc_a_tag = '0; alloc_a_val = '0;
        alloc_b_kind = '0; alloc_b_tag = '0; alloc_b_val = '0;
        bc_valid = '0; bc_tag = '0; bc_data = '0; disp_free = '1;
    endtask

    task automatic tick();
        #1;
        compare();
        model_step();
        @(posedge clk);
        @(negedge clk);
        clear_inputs();
    endtask

    task automatic put(input int l, input int op, input int port, input int dst,
                       input logic [1:0] ka, input int ta, input int va,
                       input logic [1:0] kb, input int tb, input int vb);
        alloc_valid[l] = 1; alloc_op[l] = OW'(op); alloc_port[l] = PW'(port);
        alloc_dst[l] = TW'(dst);
        alloc_a_kind[l] = ka; alloc_a_tag[l] = TW'(ta); alloc_a_val[l] = DW'(va);
        alloc_b_kind[l] = kb; alloc_b_tag[l] = TW'(tb); alloc_b_val[l] = DW'(vb);
    endtask

    task automatic bcast(input int b, input int t, input int d);
        bc_valid[b] = 1; bc_tag[b] = TW'(t); bc_data[b] = DW'(d);
    endtask

    task automatic drain();
        for (int n = 0; n < 12; n++) tick();
    endtask

    task automatic finish_run();
        done = 1;
        $display("test done: total=%0d bad=%0d", checks, bad);
        $finish;
    endtask

    initial begin
        #(CLK_PERIOD * 200000);
        if (!done) begin
            checks++; bad++;
            $display("FAIL watchdog: got hung exp finished");
            finish_run();
        end
    end

    initial begin
        for (int e = 0; e < ENT; e++) m_live[e] = 0;
        clear_inputs();
        rst = 1;
        repeat (3) @(posedge clk);
        @(negedge clk);
        rst = 0;

        // R1: empty after reset
        cur_req = "R1";
        tick();

        // R3 R9 R11: four ready micro-ops to four ports, all leave together
        cur_req = "R3";
        put(0, 1, 0, 10, SRC_COMMITTED, 0, 16'h1111, SRC_DONE_ROB, 0, 16'h2222);
        put(1, 2, 1, 11, SRC_DONE_ROB,  0, 16'h3333, SRC_COMMITTED, 0, 16'h4444);
        put(2, 3, 2, 12, SRC_COMMITTED, 0, 16'h5555, SRC_COMMITTED, 0, 16'h6666);
        put(3, 4, 3, 13, SRC_DONE_ROB,  0, 16'h7777, SRC_DONE_ROB,  0, 16'h8888);
        tick();
        cur_req = "R9";
        tick();
        tick();

        // R4 R5: waiting source held until its tag appears on bus 2
        cur_req = "R4";
        put(0, 5, 1, 20, SRC_COMMITTED, 0, 16'h0aaa, SRC_WAIT, 5, 0);
        tick();
        tick();
        tick();
        cur_req = "R5";
        bcast(2, 5, 16'hbeef);
        bcast(3, 5, 16'hdead);
        tick();
        tick();
        tick();

        // R6: broadcast in the allocation cycle itself
        cur_req = "R6";
        put(1, 6, 2, 21, SRC_WAIT_ALT, 9, 0, SRC_WAIT, 9, 0);
        bcast(0, 9, 16'hc0de);
        tick();
        tick();
        tick();

        // R8 R7: port 0 blocked, three ready micro-ops queue up, oldest first
        cur_req = "R7";
        disp_free = 4'b1110;
        put(0, 7, 0, 30, SRC_COMMITTED, 0, 1, SRC_COMMITTED, 0, 2);
        put(2, 8, 0, 31, SRC_COMMITTED, 0, 3, SRC_COMMITTED, 0, 4);
        tick();
        cur_req = "R8";
        disp_free = 4'b1110;
        put(0, 9, 0, 32, SRC_COMMITTED, 0, 5, SRC_COMMITTED, 0, 6);
        tick();
        disp_free = 4'b1110;
        tick();
        tick();
        tick();
        tick();
        drain();

        // R2 R12: fill to 20, wake one group of four, space returns
        cur_req = "R2";
        for (int c = 0; c < 5; c++) begin
            for (int l = 0; l < LN; l++)
                put(l, 16 + c * 4 + l, l, 40 + c, SRC_WAIT, (c == 0) ? 30 : 31, 0,
                    SRC_COMMITTED, 0, c * 16 + l);
            tick();
        end
        tick();
        cur_req = "R12";
        bcast(1, 30, 16'h0303);
        tick();
        tick();
        tick();
        bcast(0, 31, 16'h3131);
        tick();
        drain();

        // R10: flush drops held micro-ops and same-cycle allocations
        cur_req = "R10";
        disp_free = '0;
        put(0, 50, 0, 1, SRC_COMMITTED, 0, 1, SRC_COMMITTED, 0, 1);
        put(1, 51, 1, 2, SRC_COMMITTED, 0, 1, SRC_WAIT, 44, 0);
        tick();
        flush = 1;
        put(0, 52, 2, 3, SRC_COMMITTED, 0, 1, SRC_COMMITTED, 0, 1);
        tick();
        bcast(0, 44, 16'h4444);
        tick();
        tick();

        // mixed random traffic
        cur_req = "R7";
        for (int n = 0; n < 1500; n++) begin
            flush = (($urandom % 50) == 0);
            if ((free_cnt() >= LN) && ($urandom % 2)) begin
                for (int l = 0; l < LN; l++)
                    if (($urandom % 4) != 0)
                        put(l, $urandom % 64, $urandom % NP, $urandom % 64,
                            2'($urandom), $urandom % 12, $urandom,
                            2'($urandom), $urandom % 12, $urandom);
            end
            for (int b = 0; b < NB; b++)
                if ($urandom % 2) bcast(b, $urandom % 12, $urandom);
            disp_free = NP'($urandom) | NP'($urandom);
            tick();
        end
        drain();

        finish_run();
    end

endmodule